// File: doc/BRIEF.md
# Ethernet Receive Frame Formatter

This block takes one received Ethernet frame as a byte stream with start and end markers and lays it out in a single 2 KB page of packet RAM through a byte-wide write port. At the start marker it checks the receive configuration and whether the page allocator is offering a free page. If it accepts the frame, it claims that page. It then stores the frame data from byte 4 onward. After the last data byte it adds zero padding up to the 64-byte minimum, an optional CRC-32, a two-byte trailer, and finally the four-byte header: a status word and a byte count. The header goes last because both fields depend on the final length.

Every frame, kept or dropped, ends with a one-cycle done pulse. The pulse carries an accept flag and the page used, so that a surrounding queue can either push the page or give it back. The stream is stalled with a ready signal while padding, CRC, trailer and header are written, and for one cycle at each frame start while the page is claimed.

Top module: `eth_rx_formatter`

## Requirements
- R1: A frame whose start beat arrives while rxEnable is 0 or softReset is 1 is consumed without any page claim or RAM write, and it ends with rxDone while rxOk is 0.
- R2: A frame whose start beat arrives while freeValid is 0 is consumed the same way: no page claim, no write, and rxDone with rxOk 0.
- R3: An accepted frame claims the offered page with exactly one takePage pulse. All of its writes target that page, and rxPage reports it along with rxDone.
- R4: Bytes 0 (low) and 1 (high) hold a status word. Bit 12 is set for an odd frame length and bit 11 for a length above 1518. All other bits are 0.
- R5: Bytes 2 (low) and 3 (high) hold a byte count. It is the data length (64 for frames shorter than 64, otherwise the length rounded down to even) plus 6, plus 4 more when stripCrc is 0.
- R6: Frame bytes are stored in order from byte 4. A frame shorter than 64 bytes keeps all of its bytes in place and is zero-filled up to 64 data bytes. Nothing is written past the trailer.
- R7: When stripCrc is 0, the inverted reflected CRC-32 (preset all ones) of the frame, or of the 64 padded bytes for a short frame, follows the even-aligned data, least significant byte first.
- R8: The last two bytes written before the header are the trailer. For a frame of odd length of at least 64, it is the final frame byte followed by 0x60. Otherwise it is 0x00 followed by 0x40.
- R9: A frame longer than the longest one whose byte count fits in 2048 (2039 bytes with CRC kept, 2043 with CRC stripped) is dropped: rxOk is 0 and the header bytes 0 to 3 are never written.
- R10: rxDone is high for exactly one cycle per frame, after the last RAM write of that frame.
- R11: While idle, beats without the start marker are consumed and ignored: no write, no page claim, no rxDone.
- R12: After reset the block is idle: inReady is 1 while no start beat is offered, and memWe, takePage and rxDone are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Receive enable, sampled at frame start |
| softReset | input | 1 | Soft reset level, frames are dropped while high |
| stripCrc | input | 1 | 1 = do not append CRC, sampled at frame start |
| inValid | input | 1 | Stream byte valid |
| inReady | output | 1 | Stream byte accepted when high with inValid |
| inData | input | 8 | Stream byte |
| inFirst | input | 1 | Marks the first byte of a frame |
| inLast | input | 1 | Marks the last byte of a frame |
| freeValid | input | 1 | Allocator has a free page on offer |
| freePage | input | 2 | Offered page number |
| takePage | output | 1 | Pulse: offered page is claimed |
| memWe | output | 1 | Packet RAM byte write enable |
| memPage | output | 2 | Page of the write |
| memAddr | output | 11 | Byte offset within the page |
| memData | output | 8 | Byte written |
| rxDone | output | 1 | One-cycle end-of-frame pulse |
| rxOk | output | 1 | With rxDone: 1 = frame stored, 0 = dropped |
| rxPage | output | 2 | With rxDone: page used by the frame |

## Verification
The oversize test and the end of the frame can land on the same beat: the byte that carries the end marker can also be the one that pushes the length past the limit. Frames of exactly 2040 bytes with CRC kept and 2044 bytes with CRC stripped provoke this. They are judged by rxOk being 0 and the four header bytes keeping the fill pattern. The neighbours one byte shorter must be accepted, with their trailer landing on the very last byte of the page. A 2100-byte frame covers the case where the overflow comes before the end marker and the rest of the frame is discarded.

// File: rtl/eth_rxfmt_pkg.sv
package eth_rxfmt_pkg;

  localparam logic [31:0] CRC_POLY_REV = 32'hEDB88320;
  localparam int HDR_BYTES = 4;
  localparam int CRC_BYTES = 4;
  localparam int STAT_ODD_BIT = 12;
  localparam int STAT_LONG_BIT = 11;
  localparam logic [7:0] TRAIL_ODD = 8'h60;
  localparam logic [7:0] TRAIL_EVEN = 8'h40;

  typedef enum logic [2:0] {
    SRC_DATA,
    SRC_PAD,
    SRC_CRC,
    SRC_TRAIL,
    SRC_HDR
  } wrSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   start;     // claim page, clear length/crc/pointer
    logic   takeByte;  // count input byte and fold into crc
    logic   holdLast;  // keep the odd final byte for the trailer
    logic   write;     // issue one RAM byte write
    wrSrc_e src;       // what the write carries
    logic   subClr;    // last byte of a multi-byte field
  } fmtCtl_t;

  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REV) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_rxfmt_datapath.sv
module eth_rxfmt_datapath
  import eth_rxfmt_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int PAGE_W = 2,
  parameter int MIN_FRAME = 64,
  parameter int LONG_FRAME = 1518,
  localparam int ADDR_W = $clog2(PAGE_BYTES),
  localparam int LEN_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fmtCtl_t           ctl,
  input  logic [7:0]        inData,
  input  logic              stripCrc,
  input  logic [PAGE_W-1:0] freePage,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic [PAGE_W-1:0] pageOut,
  output logic              atLimit,
  output logic              nextOdd,
  output logic              nextShort,
  output logic              padLast,
  output logic              keepCrc,
  output logic [1:0]        subIdx
);

  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);
  localparam logic [LEN_W-1:0] MIN_M1_L = LEN_W'(MIN_FRAME - 1);
  localparam logic [LEN_W-1:0] LONG_L = LEN_W'(LONG_FRAME);
  localparam logic [LEN_W-1:0] PAGE_L = LEN_W'(PAGE_BYTES);
  localparam logic [LEN_W-1:0] HDR_L = LEN_W'(HDR_BYTES);
  localparam logic [LEN_W-1:0] PAD_END_L = LEN_W'(HDR_BYTES + MIN_FRAME - 1);
  localparam logic [LEN_W-1:0] MAX_KEEP_L = LEN_W'(PAGE_BYTES - HDR_BYTES - 2 - CRC_BYTES + 1);
  localparam logic [LEN_W-1:0] MAX_STRIP_L = LEN_W'(PAGE_BYTES - HDR_BYTES - 2 + 1);

  logic [LEN_W-1:0]  lenQ;
  logic [LEN_W-1:0]  wrPtr;
  logic [31:0]       crcQ;
  logic [7:0]        holdQ;
  logic [PAGE_W-1:0] pageQ;
  logic              keepQ;
  logic [1:0]        subQ;

  logic              multiByte;
  assign multiByte = (ctl.src == SRC_CRC) || (ctl.src == SRC_TRAIL) || (ctl.src == SRC_HDR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenQ  <= '0;
      wrPtr <= '0;
      crcQ  <= '1;
      holdQ <= '0;
      pageQ <= '0;
      keepQ <= 1'b0;
      subQ  <= '0;
    end else if (ctl.start) begin
      lenQ  <= '0;
      wrPtr <= HDR_L;
      crcQ  <= '1;
      pageQ <= freePage;
      keepQ <= !stripCrc;
      subQ  <= '0;
    end else begin
      if (ctl.takeByte) begin
        lenQ <= lenQ + 1'b1;
        crcQ <= crcStep(crcQ, inData);
      end else if (ctl.write && ctl.src == SRC_PAD) begin
        crcQ <= crcStep(crcQ, 8'd0);
      end
      if (ctl.holdLast) holdQ <= inData;
      if (ctl.write && ctl.src != SRC_HDR) wrPtr <= wrPtr + 1'b1;
      if (ctl.write && multiByte) subQ <= ctl.subClr ? 2'd0 : subQ + 2'd1;
    end
  end

  logic              shortFrame;
  logic              trailOdd;
  logic [LEN_W-1:0]  padEven;
  logic [15:0]       statusW;
  logic [15:0]       countW;
  logic [31:0]       crcOut;

  assign shortFrame = lenQ < MIN_L;
  assign trailOdd   = lenQ[0] && !shortFrame;
  assign padEven    = shortFrame ? MIN_L : {lenQ[LEN_W-1:1], 1'b0};
  assign crcOut     = ~crcQ;
  assign countW     = 16'(padEven) + 16'(HDR_BYTES + 2) + (keepQ ? 16'(CRC_BYTES) : 16'd0);

  always_comb begin
    statusW = '0;
    statusW[STAT_ODD_BIT]  = lenQ[0];
    statusW[STAT_LONG_BIT] = lenQ > LONG_L;
  end

  always_comb begin
    memAddr = wrPtr[ADDR_W-1:0];
    memData = 8'd0;
    case (ctl.src)
      SRC_DATA:  memData = inData;
      SRC_PAD:   memData = 8'd0;
      SRC_CRC:   memData = crcOut[8*subQ +: 8];
      SRC_TRAIL: begin
        if (subQ == 2'd0) memData = trailOdd ? holdQ : 8'd0;
        else              memData = trailOdd ? TRAIL_ODD : TRAIL_EVEN;
      end
      SRC_HDR: begin
        memAddr = ADDR_W'(subQ);
        case (subQ)
          2'd0:    memData = statusW[7:0];
          2'd1:    memData = statusW[15:8];
          2'd2:    memData = countW[7:0];
          default: memData = countW[15:8];
        endcase
      end
      default: memData = 8'd0;
    endcase
  end

  assign pageOut   = pageQ;
  assign keepCrc   = keepQ;
  assign subIdx    = subQ;
  assign atLimit   = lenQ == (keepQ ? MAX_KEEP_L : MAX_STRIP_L);
  assign nextOdd   = !lenQ[0];
  assign nextShort = lenQ < MIN_M1_L;
  assign padLast   = wrPtr == PAD_END_L;

  // R9
  ptr_in_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.write && ctl.src != SRC_HDR) |-> (wrPtr < PAGE_L));

  // R6
  pad_after_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.write && ctl.src == SRC_PAD) |-> (lenQ < MIN_L));

endmodule

// File: rtl/eth_rxfmt_ctrl.sv
module eth_rxfmt_ctrl
  import eth_rxfmt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  logic       softReset,
  input  logic       freeValid,
  input  logic       inValid,
  input  logic       inFirst,
  input  logic       inLast,
  input  logic       atLimit,
  input  logic       nextOdd,
  input  logic       nextShort,
  input  logic       padLast,
  input  logic       keepCrc,
  input  logic [1:0] subIdx,
  output fmtCtl_t    ctl,
  output logic       inReady,
  output logic       takePage,
  output logic       rxDone,
  output logic       rxOk
);

  typedef enum logic [2:0] {
    S_IDLE, S_RECV, S_SKIP, S_PAD, S_CRC, S_TRAIL, S_HDR, S_DONE
  } state_e;

  state_e stateQ, stateN;
  logic   okQ, okN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      okQ    <= 1'b0;
    end else begin
      stateQ <= stateN;
      okQ    <= okN;
    end
  end

  always_comb begin
    ctl      = '0;
    ctl.src  = SRC_DATA;
    inReady  = 1'b0;
    takePage = 1'b0;
    stateN   = stateQ;
    okN      = okQ;
    case (stateQ)
      S_IDLE: begin
        inReady = !inFirst;
        if (inValid && inFirst) begin
          if (rxEnable && !softReset && freeValid) begin
            ctl.start = 1'b1;
            takePage  = 1'b1;
            stateN    = S_RECV;
          end else begin
            okN    = 1'b0;
            stateN = S_SKIP;
          end
        end
      end
      S_RECV: begin
        inReady = 1'b1;
        if (inValid) begin
          if (atLimit) begin
            okN    = 1'b0;
            stateN = inLast ? S_DONE : S_SKIP;
          end else begin
            ctl.takeByte = 1'b1;
            if (inLast && nextOdd && !nextShort) begin
              ctl.holdLast = 1'b1;
            end else begin
              ctl.write = 1'b1;
              ctl.src   = SRC_DATA;
            end
            if (inLast) stateN = nextShort ? S_PAD : (keepCrc ? S_CRC : S_TRAIL);
          end
        end
      end
      S_SKIP: begin
        inReady = 1'b1;
        if (inValid && inLast) stateN = S_DONE;
      end
      S_PAD: begin
        ctl.write = 1'b1;
        ctl.src   = SRC_PAD;
        if (padLast) stateN = keepCrc ? S_CRC : S_TRAIL;
      end
      S_CRC: begin
        ctl.write = 1'b1;
        ctl.src   = SRC_CRC;
        if (subIdx == 2'd3) begin
          ctl.subClr = 1'b1;
          stateN     = S_TRAIL;
        end
      end
      S_TRAIL: begin
        ctl.write = 1'b1;
        ctl.src   = SRC_TRAIL;
        if (subIdx == 2'd1) begin
          ctl.subClr = 1'b1;
          stateN     = S_HDR;
        end
      end
      S_HDR: begin
        ctl.write = 1'b1;
        ctl.src   = SRC_HDR;
        if (subIdx == 2'd3) begin
          ctl.subClr = 1'b1;
          okN        = 1'b1;
          stateN     = S_DONE;
        end
      end
      S_DONE:  stateN = S_IDLE;
      default: stateN = S_IDLE;
    endcase
  end

  assign rxDone = stateQ == S_DONE;
  assign rxOk   = okQ;

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone);

  // R10
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && rxOk) |-> $past(ctl.write));

  // R1
  take_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    takePage |-> (rxEnable && !softReset));

  // R2
  take_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    takePage |-> freeValid);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |-> (!ctl.write && !inReady));

endmodule

// File: rtl/eth_rx_formatter.sv
module eth_rx_formatter
  import eth_rxfmt_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int PAGE_W = 2,
  parameter int MIN_FRAME = 64,
  parameter int LONG_FRAME = 1518,
  localparam int ADDR_W = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              softReset,
  input  logic              stripCrc,
  input  logic              inValid,
  output logic              inReady,
  input  logic [7:0]        inData,
  input  logic              inFirst,
  input  logic              inLast,
  input  logic              freeValid,
  input  logic [PAGE_W-1:0] freePage,
  output logic              takePage,
  output logic              memWe,
  output logic [PAGE_W-1:0] memPage,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic              rxDone,
  output logic              rxOk,
  output logic [PAGE_W-1:0] rxPage
);

  fmtCtl_t     ctl;
  logic        atLimit, nextOdd, nextShort, padLast, keepCrc;
  logic [1:0]  subIdx;
  logic [PAGE_W-1:0] pageQ;

  eth_rxfmt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .rxEnable(rxEnable), .softReset(softReset), .freeValid(freeValid),
    .inValid(inValid), .inFirst(inFirst), .inLast(inLast),
    .atLimit(atLimit), .nextOdd(nextOdd), .nextShort(nextShort),
    .padLast(padLast), .keepCrc(keepCrc), .subIdx(subIdx),
    .ctl(ctl), .inReady(inReady), .takePage(takePage),
    .rxDone(rxDone), .rxOk(rxOk)
  );

  eth_rxfmt_datapath #(
    .PAGE_BYTES(PAGE_BYTES), .PAGE_W(PAGE_W),
    .MIN_FRAME(MIN_FRAME), .LONG_FRAME(LONG_FRAME)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData),
    .stripCrc(stripCrc), .freePage(freePage),
    .memAddr(memAddr), .memData(memData), .pageOut(pageQ),
    .atLimit(atLimit), .nextOdd(nextOdd), .nextShort(nextShort),
    .padLast(padLast), .keepCrc(keepCrc), .subIdx(subIdx)
  );

  assign memWe   = ctl.write;
  assign memPage = pageQ;
  assign rxPage  = pageQ;

endmodule

// File: tb/eth_rx_formatter_tb.sv
module eth_rx_formatter_tb_top;

  localparam int PAGE = 2048;
  localparam int NV = 16;

  typedef struct packed {
    int         len;
    logic [7:0] seed;
    logic       en;
    logic       srst;
    logic       strip;
    logic       free;
    logic       expOk;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{64,   8'h11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{63,   8'h22, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{10,   8'h33, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    '{65,   8'h44, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{1519, 8'h55, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{100,  8'h66, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    '{70,   8'h77, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{70,   8'h88, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{70,   8'h99, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2039, 8'hA1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{2040, 8'hB2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{2043, 8'hC3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    '{2044, 8'hD4, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    '{1,    8'hE5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{2100, 8'hF6, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1518, 8'h17, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEnable = 1'b0, softReset = 1'b0, stripCrc = 1'b0;
  logic inValid = 1'b0, inFirst = 1'b0, inLast = 1'b0;
  logic [7:0] inData = 8'd0;
  logic freeValid = 1'b0;
  logic [1:0] freePage = 2'd0;
  logic inReady, takePage, memWe, rxDone, rxOk;
  logic [1:0] memPage, rxPage;
  logic [10:0] memAddr;
  logic [7:0] memData;

  always #2.5 clk = ~clk;

  eth_rx_formatter dut_i (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .softReset(softReset),
    .stripCrc(stripCrc), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inFirst(inFirst), .inLast(inLast), .freeValid(freeValid), .freePage(freePage),
    .takePage(takePage), .memWe(memWe), .memPage(memPage), .memAddr(memAddr),
    .memData(memData), .rxDone(rxDone), .rxOk(rxOk), .rxPage(rxPage)
  );

  // capture of the page writes and pulses
  logic [7:0] pageMem [PAGE];
  logic clearMem = 1'b0;
  int writeCount, takeCount, doneCount, badPage;
  logic lastOk;
  logic [1:0] lastPage;

  always @(posedge clk) begin
    if (clearMem) begin
      for (int k = 0; k < PAGE; k++) pageMem[k] <= 8'hEE;
      writeCount <= 0; takeCount <= 0; doneCount <= 0; badPage <= 0;
    end else begin
      if (memWe) begin
        pageMem[memAddr] <= memData;
        writeCount <= writeCount + 1;
        if (memPage != freePage) badPage <= badPage + 1;
      end
      if (takePage) takeCount <= takeCount + 1;
      if (rxDone) begin
        doneCount <= doneCount + 1;
        lastOk <= rxOk;
        lastPage <= rxPage;
      end
    end
  end

  int nChecks = 0;
  int nFail = 0;

  task automatic checkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  function automatic logic [7:0] fb(input logic [7:0] seed, input int i);
    return seed + 8'(i * 13) + 8'(i >> 8);
  endfunction

  function automatic logic [31:0] refCrc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ 32'hEDB88320;
      else r = r >> 1;
    end
    return r;
  endfunction

  logic [7:0] expImg [PAGE];
  int expEnd;

  task automatic buildExpected(input int len, input logic [7:0] seed, input logic keep);
    int even, padded, cnt, p, crcLen;
    logic [15:0] st;
    logic [31:0] c;
    logic shortF;
    even = len & ~1;
    shortF = len < 64;
    padded = shortF ? 64 : even;
    cnt = padded + 6 + (keep ? 4 : 0);
    st = 16'd0;
    st[12] = len[0];
    st[11] = len > 1518;
    expImg[0] = st[7:0]; expImg[1] = st[15:8];
    expImg[2] = 8'(cnt); expImg[3] = 8'(cnt >> 8);
    for (int i = 0; i < even; i++) expImg[4 + i] = fb(seed, i);
    if (shortF) begin
      if (len[0]) expImg[4 + len - 1] = fb(seed, len - 1);
      for (int i = len; i < 64; i++) expImg[4 + i] = 8'd0;
    end
    p = 4 + padded;
    c = 32'hFFFFFFFF;
    crcLen = shortF ? 64 : len;
    for (int i = 0; i < crcLen; i++) c = refCrc(c, (i < len) ? fb(seed, i) : 8'd0);
    c = ~c;
    if (keep) begin
      for (int k = 0; k < 4; k++) expImg[p + k] = c[8*k +: 8];
      p = p + 4;
    end
    if (!shortF && len[0]) begin
      expImg[p] = fb(seed, len - 1); expImg[p + 1] = 8'h60;
    end else begin
      expImg[p] = 8'h00; expImg[p + 1] = 8'h40;
    end
    expEnd = p + 2;
  endtask

  task automatic clearCapture();
    @(negedge clk) clearMem = 1'b1;
    @(negedge clk) clearMem = 1'b0;
  endtask

  task automatic sendFrame(input int len, input logic [7:0] seed, input logic withFirst);
    int i;
    logic acc;
    i = 0;
    while (i < len) begin
      @(negedge clk);
      inValid = 1'b1;
      inData = fb(seed, i);
      inFirst = withFirst && (i == 0);
      inLast = (i == len - 1);
      #1 acc = inReady;
      @(posedge clk);
      if (acc) i++;
    end
    @(negedge clk);
    inValid = 1'b0; inFirst = 1'b0; inLast = 1'b0;
  endtask

  task automatic waitDone();
    while (doneCount == 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int mHdrS, mHdrC, mData, mCrc, mTrl, hdrKept;
    vec_t v;
    string dropTag;
    repeat (3) @(negedge clk);
    clearCapture();
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R12 reset state
    checkEq("R12 inReady idle", int'(inReady), 1);
    checkEq("R12 memWe idle", int'(memWe), 0);
    checkEq("R12 rxDone idle", int'(rxDone), 0);
    checkEq("R12 takePage idle", int'(takePage), 0);

    for (int n = 0; n < NV; n++) begin
      v = VECS[n];
      clearCapture();
      rxEnable = v.en; softReset = v.srst; stripCrc = v.strip;
      freeValid = v.free; freePage = 2'(n);
      sendFrame(v.len, v.seed, 1'b1);
      waitDone();
      checkEq("R10 one done pulse", doneCount, 1);
      if (!v.en || v.srst || !v.free) dropTag = (!v.free) ? "R2" : "R1";
      else dropTag = "R9";
      if (!v.expOk) begin
        checkEq({dropTag, " drop rxOk"}, int'(lastOk), 0);
        if (dropTag != "R9") begin
          checkEq({dropTag, " no writes"}, writeCount, 0);
          checkEq({dropTag, " no claim"}, takeCount, 0);
        end else begin
          hdrKept = 0;
          for (int k = 0; k < 4; k++) if (pageMem[k] == 8'hEE) hdrKept++;
          checkEq("R9 header untouched", hdrKept, 4);
        end
      end else begin
        buildExpected(v.len, v.seed, !v.strip);
        checkEq("R3 accept rxOk", int'(lastOk), 1);
        checkEq("R3 one claim", takeCount, 1);
        checkEq("R3 page on writes", badPage, 0);
        checkEq("R3 rxPage", int'(lastPage), n % 4);
        mHdrS = 0; mHdrC = 0; mData = 0; mCrc = 0; mTrl = 0;
        for (int k = 0; k < expEnd; k++) begin
          if (pageMem[k] != expImg[k]) begin
            if (k < 2) mHdrS++;
            else if (k < 4) mHdrC++;
            else if (k >= expEnd - 2) mTrl++;
            else if (!v.strip && k >= expEnd - 6) mCrc++;
            else mData++;
          end
        end
        checkEq("R4 status word", mHdrS, 0);
        checkEq("R5 byte count", mHdrC, 0);
        checkEq("R6 data and pad", mData, 0);
        if (!v.strip) checkEq("R7 crc bytes", mCrc, 0);
        checkEq("R8 trailer", mTrl, 0);
        checkEq("R6 write count", writeCount, expEnd);
        if (expEnd < PAGE) checkEq("R6 nothing past trailer", int'(pageMem[expEnd]), 8'hEE);
      end
    end

    // R11 beats without start marker while idle
    clearCapture();
    rxEnable = 1'b1; softReset = 1'b0; freeValid = 1'b1;
    sendFrame(5, 8'h5A, 1'b0);
    repeat (4) @(negedge clk);
    checkEq("R11 no writes", writeCount, 0);
    checkEq("R11 no claim", takeCount, 0);
    checkEq("R11 no done", doneCount, 0);

    // R12 reset in the middle of a frame returns to idle
    clearCapture();
    @(negedge clk);
    inValid = 1'b1; inFirst = 1'b1; inData = 8'h01; inLast = 1'b0;
    repeat (3) @(negedge clk);
    inFirst = 1'b0;
    repeat (5) @(negedge clk);
    inValid = 1'b0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    checkEq("R12 inReady after reset", int'(inReady), 1);
    checkEq("R12 memWe after reset", int'(memWe), 0);
    checkEq("R12 no done after reset", doneCount, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule